// File: doc/BRIEF.md
# Hub Master Control Register Bank

This block is the software-visible control plane of a hub master that fans one upstream service-bus link out to several downstream links. A simple 32-bit word register bus reads and writes it. It holds the operating mode, the delay and clock-rate words, the per-link enable mask and the error-control bits. It reports a version word that carries the implemented link count, the plug-detect levels and an error-status word that arrives on an input port. Writes to two command addresses produce one-cycle reset pulses for the master, the link controllers, the parity logic and the bridge.

The bank also decodes upstream addresses. Everything from byte 0x80000 upward is split into windows of 0x80000 bytes, one window per downstream link. The block reports the target link and the offset inside that window. It refuses any access whose link is not implemented or not enabled, and it latches the address of the most recent refused access.

Link n always sits at bit (31 − n) of the enable and plug words, so link 0 is the most significant bit. The link count is the parameter `N_LINKS` (at most 8).

Top module: `hub_ctrl_regs`

## Requirements
- R1: After reset every link enable, mode field, delay word, clock-rate word, error-control bit, latched refused address and pulse output is zero. A read returns its data on `bus_rdata` on the clock edge that takes the read, and that value holds until the next read.
- R2: Offset 0x0 is the mode register. Interrupt-poll enable is bit 31, error-recovery enable bit 30, parity enable bit 28, clock select A bits [27:18], clock select B bits [17:8] and timeout select bit 4. All other bits read as zero. Offsets 0x4 (delay) and 0x8 (clock rate) are full 32-bit read/write words.
- R3: Link n maps to bit (31 − n) of the enable word. Offset 0x10 writes the enable word directly and reads it back. Bits of links at or above `N_LINKS` read as zero.
- R4: A write to 0x18 ORs each 1 bit into the enable mask and leaves links written as 0 unchanged. A read of 0x18 returns the plug levels in the same bit mapping.
- R5: A write to 0x20 clears the enable of every link written as 1 and leaves the other links unchanged.
- R6: Offset 0x74 reads as the version word: the link count in bits [15:8] and the revision parameter in bits [7:0]. Writes to it change nothing.
- R7: A write to 0xD0 raises a one-cycle pulse in the cycle after the write for each set bit: bit 29 resets all masters, bit 28 resets all link controllers, bit 27 resets the master registers and bit 26 clears the parity error. Clear bits give no pulse.
- R8: A 0xD0 write with bit 27 set returns the mode, delay, enable and error-control registers to zero.
- R9: A write to 0x1D0 gives a one-cycle general bridge reset pulse for bit 31 and an error reset pulse for bit 30. A read of 0x1D0 returns the error-status input.
- R10: Offset 0x2E0 holds machine-check-on-error in bit 15 and auto-terminate in bit 14. It drives both outputs and reads back those bits only.
- R11: An upstream access at or above 0x80000 targets link (addr − 0x80000) / 0x80000 with offset addr[18:0]. It is forwarded (`fwd_valid`) when that link is implemented and enabled.
- R12: An upstream access to a window whose link is not implemented or not enabled raises `fwd_err` and is not forwarded. Offset 0x70 reads the most recently refused address. Addresses below 0x80000 raise neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| plug_lvl | input | N_LINKS | Plug-detect level per link |
| err_status | input | 32 | Master error status word |
| up_valid | input | 1 | Upstream access present |
| up_addr | input | ADDR_W | Upstream byte address |
| fwd_valid | output | 1 | Access forwarded to a link |
| fwd_err | output | 1 | Access refused |
| fwd_link | output | 3 | Target link index |
| fwd_offset | output | 19 | Offset inside the link window |
| link_en | output | N_LINKS | Per-link enable |
| poll_en | output | 1 | Interrupt-poll enable |
| recov_en | output | 1 | Error-recovery enable |
| parity_en | output | 1 | Parity-check enable |
| clk_sel_a | output | 10 | Clock select A |
| clk_sel_b | output | 10 | Clock select B |
| tmo_sel | output | 1 | Timeout select |
| delay_word | output | 32 | Delay register |
| rate_word | output | 32 | Clock-rate register |
| mchk_en | output | 1 | Machine check on error |
| auto_term | output | 1 | Auto-terminate |
| rst_masters | output | 1 | Pulse: reset all masters |
| rst_links | output | 1 | Pulse: reset all link controllers |
| rst_regs | output | 1 | Pulse: master registers reset |
| clr_parity | output | 1 | Pulse: clear parity error |
| brg_gen_rst | output | 1 | Pulse: bridge general reset |
| brg_err_rst | output | 1 | Pulse: bridge error reset |

## Verification
The bench targets the mirrored bit order, where a design that mapped link 0 to bit 0 would read back, enable and forward the wrong links. It checks that set and clear writes touch only the links written as 1, so a design that copied the word instead would lose enables. Out-of-range and disabled windows must raise the error and latch their address, where a faulty decoder would forward into a missing link. The reset-command pulses must last exactly one cycle and the register reset must wipe the mode, delay, enable and error-control state, so a stuck pulse or a partial clear shows up directly at the ports.

// File: rtl/hub_ctrl_regs.sv
module hub_ctrl_regs #(
  parameter int N_LINKS = 6,
  parameter int ADDR_W  = 24,
  parameter logic [7:0] HUB_REV = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_LINKS-1:0] plug_lvl,
  input  logic [31:0]       err_status,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  output logic              fwd_valid,
  output logic              fwd_err,
  output logic [2:0]        fwd_link,
  output logic [18:0]       fwd_offset,
  output logic [N_LINKS-1:0] link_en,
  output logic              poll_en,
  output logic              recov_en,
  output logic              parity_en,
  output logic [9:0]        clk_sel_a,
  output logic [9:0]        clk_sel_b,
  output logic              tmo_sel,
  output logic [31:0]       delay_word,
  output logic [31:0]       rate_word,
  output logic              mchk_en,
  output logic              auto_term,
  output logic              rst_masters,
  output logic              rst_links,
  output logic              rst_regs,
  output logic              clr_parity,
  output logic              brg_gen_rst,
  output logic              brg_err_rst
);
  localparam int WIN_SH = 19;
  localparam int IDX_W  = ADDR_W - WIN_SH;

  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_DLY   = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] A_RATE  = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'('h018);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'('h020);
  localparam logic [ADDR_W-1:0] A_BAD   = ADDR_W'('h070);
  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'('h074);
  localparam logic [ADDR_W-1:0] A_PORT  = ADDR_W'('h0D0);
  localparam logic [ADDR_W-1:0] A_BRG   = ADDR_W'('h1D0);
  localparam logic [ADDR_W-1:0] A_ECTL  = ADDR_W'('h2E0);

  function automatic logic [N_LINKS-1:0] to_links(input logic [31:0] w);
    for (int n = 0; n < N_LINKS; n++) to_links[n] = w[31-n];
  endfunction

  function automatic logic [31:0] to_word(input logic [N_LINKS-1:0] l);
    to_word = '0;
    for (int n = 0; n < N_LINKS; n++) to_word[31-n] = l[n];
  endfunction

  logic [31:0] bad_addr;
  logic [31:0] rmux;
  logic [31:0] mode_word;
  logic [N_LINKS-1:0] wmask;

  wire wr = bus_sel && bus_we;
  wire rd = bus_sel && !bus_we;

  assign wmask = to_links(bus_wdata);
  assign mode_word = {poll_en, recov_en, 1'b0, parity_en, clk_sel_a, clk_sel_b, 3'b0, tmo_sel, 4'b0};

  // window decode
  logic [IDX_W-1:0] win_idx, lnk_i;
  logic in_win, impl, en_hit;
  logic [31:0] en_ext;
  assign win_idx = up_addr[ADDR_W-1:WIN_SH];
  assign lnk_i   = win_idx - IDX_W'(1);
  assign in_win  = win_idx != '0;
  assign impl    = lnk_i < IDX_W'(N_LINKS);
  assign en_ext  = 32'(link_en);
  assign en_hit  = impl && en_ext[5'(lnk_i)];
  assign fwd_valid  = up_valid && in_win && en_hit;
  assign fwd_err    = up_valid && in_win && !en_hit;
  assign fwd_link   = lnk_i[2:0];
  assign fwd_offset = up_addr[WIN_SH-1:0];

  always_comb begin
    case (bus_addr)
      A_MODE:  rmux = mode_word;
      A_DLY:   rmux = delay_word;
      A_RATE:  rmux = rate_word;
      A_EN:    rmux = to_word(link_en);
      A_SET:   rmux = to_word(plug_lvl);
      A_BAD:   rmux = bad_addr;
      A_VER:   rmux = {16'h0, 8'(N_LINKS), HUB_REV};
      A_BRG:   rmux = err_status;
      A_ECTL:  rmux = {16'h0, mchk_en, auto_term, 14'h0};
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bad_addr <= '0;
      link_en <= '0;
      {poll_en, recov_en, parity_en, tmo_sel} <= '0;
      clk_sel_a <= '0;
      clk_sel_b <= '0;
      delay_word <= '0;
      rate_word <= '0;
      {mchk_en, auto_term} <= '0;
      {rst_masters, rst_links, rst_regs, clr_parity} <= '0;
      {brg_gen_rst, brg_err_rst} <= '0;
    end else begin
      {rst_masters, rst_links, rst_regs, clr_parity} <= '0;
      {brg_gen_rst, brg_err_rst} <= '0;
      if (fwd_err) bad_addr <= 32'(up_addr);
      if (rd) bus_rdata <= rmux;
      if (wr) begin
        case (bus_addr)
          A_MODE: begin
            poll_en   <= bus_wdata[31];
            recov_en  <= bus_wdata[30];
            parity_en <= bus_wdata[28];
            clk_sel_a <= bus_wdata[27:18];
            clk_sel_b <= bus_wdata[17:8];
            tmo_sel   <= bus_wdata[4];
          end
          A_DLY:  delay_word <= bus_wdata;
          A_RATE: rate_word <= bus_wdata;
          A_EN:   link_en <= wmask;
          A_SET:  link_en <= link_en | wmask;
          A_CLR:  link_en <= link_en & ~wmask;
          A_PORT: begin
            rst_masters <= bus_wdata[29];
            rst_links   <= bus_wdata[28];
            rst_regs    <= bus_wdata[27];
            clr_parity  <= bus_wdata[26];
            if (bus_wdata[27]) begin
              link_en <= '0;
              {poll_en, recov_en, parity_en, tmo_sel} <= '0;
              clk_sel_a <= '0;
              clk_sel_b <= '0;
              delay_word <= '0;
              {mchk_en, auto_term} <= '0;
            end
          end
          A_BRG: begin
            brg_gen_rst <= bus_wdata[31];
            brg_err_rst <= bus_wdata[30];
          end
          A_ECTL: begin
            mchk_en   <= bus_wdata[15];
            auto_term <= bus_wdata[14];
          end
          default: ;
        endcase
      end
    end
  end

  assert_regs_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_regs |-> $past(bus_sel && bus_we && bus_addr == A_PORT && bus_wdata[27]));

  assert_set_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_SET) |=> ((link_en & $past(wmask)) == $past(wmask)) && ((link_en | $past(wmask)) == ($past(link_en) | $past(wmask))));

  assert_clr_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_CLR) |=> ((link_en & $past(wmask)) == '0));

  assert_regs_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_PORT && bus_wdata[27]) |=> (link_en == '0 && delay_word == '0 && !poll_en && !mchk_en && clk_sel_a == '0));

  assert_fwd_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (((32'(link_en) >> fwd_link) & 32'd1) != 32'd0));

  assert_bad_latch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_err |=> (bad_addr == 32'($past(up_addr))));
endmodule

// File: tb/sim_hub_ctrl_regs.sv
`timescale 1ns/1ps
module sim_hub_ctrl_regs;
  localparam int NL = 6;
  localparam int AW = 24;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0, up_addr = '0;
  logic [31:0] bus_wdata = '0, err_status = 32'hDEAD0001;
  logic [31:0] bus_rdata;
  logic [NL-1:0] plug_lvl = 6'b101001;
  logic up_valid = 0;
  logic fwd_valid, fwd_err;
  logic [2:0] fwd_link;
  logic [18:0] fwd_offset;
  logic [NL-1:0] link_en;
  logic poll_en, recov_en, parity_en, tmo_sel, mchk_en, auto_term;
  logic [9:0] clk_sel_a, clk_sel_b;
  logic [31:0] delay_word, rate_word;
  logic rst_masters, rst_links, rst_regs, clr_parity, brg_gen_rst, brg_err_rst;

  hub_ctrl_regs #(.N_LINKS(NL), .ADDR_W(AW), .HUB_REV(8'h21)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .plug_lvl(plug_lvl), .err_status(err_status),
    .up_valid(up_valid), .up_addr(up_addr), .fwd_valid(fwd_valid), .fwd_err(fwd_err),
    .fwd_link(fwd_link), .fwd_offset(fwd_offset), .link_en(link_en), .poll_en(poll_en),
    .recov_en(recov_en), .parity_en(parity_en), .clk_sel_a(clk_sel_a), .clk_sel_b(clk_sel_b),
    .tmo_sel(tmo_sel), .delay_word(delay_word), .rate_word(rate_word), .mchk_en(mchk_en),
    .auto_term(auto_term), .rst_masters(rst_masters), .rst_links(rst_links), .rst_regs(rst_regs),
    .clr_parity(clr_parity), .brg_gen_rst(brg_gen_rst), .brg_err_rst(brg_err_rst));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit live = 0, done = 0;

  // reference model state
  bit m_en [NL];
  int unsigned m_mode = 0, m_dly = 0, m_rate = 0, m_ectl = 0, m_bad = 0;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] en_word();
    logic [31:0] w = 0;
    for (int n = 0; n < NL; n++) if (m_en[n]) w = w | (32'h8000_0000 >> n);
    return w;
  endfunction

  function automatic logic [NL-1:0] en_vec();
    logic [NL-1:0] v = 0;
    for (int n = 0; n < NL; n++) v[n] = m_en[n];
    return v;
  endfunction

  // model of link decode
  always @(posedge clk) begin
    #1.25;
    if (live) begin
      int unsigned a, l;
      bit win, ok;
      a = up_addr;
      win = up_valid && a >= 32'h80000;
      l = (a - 32'h80000) / 32'h80000;
      ok = win && l < NL && m_en[l];
      check("R3 link_en", 32'(link_en), 32'(en_vec()));
      check("R2 mode outputs", {poll_en, recov_en, 1'b0, parity_en, clk_sel_a, clk_sel_b, 3'b0, tmo_sel, 4'b0}, m_mode);
      check("R2 delay", delay_word, m_dly);
      check("R10 ectl outputs", {16'h0, mchk_en, auto_term, 14'h0}, m_ectl);
      check("R11 fwd_valid", 32'(fwd_valid), 32'(ok));
      check("R12 fwd_err", 32'(fwd_err), 32'(win && !ok));
      if (ok) begin
        check("R11 fwd_link", 32'(fwd_link), l);
        check("R11 fwd_offset", 32'(fwd_offset), a % 32'h80000);
      end
    end
  end

  task automatic wr(int unsigned a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); #0.5;
    bus_sel = 0; bus_we = 0;
    case (a)
      'h0:  m_mode = d & 32'hDFFF_FF10;
      'h4:  m_dly = d;
      'h8:  m_rate = d;
      'h10: for (int n = 0; n < NL; n++) m_en[n] = d[31-n];
      'h18: for (int n = 0; n < NL; n++) if (d[31-n]) m_en[n] = 1;
      'h20: for (int n = 0; n < NL; n++) if (d[31-n]) m_en[n] = 0;
      'hD0: if (d[27]) begin
              m_mode = 0; m_dly = 0; m_ectl = 0;
              for (int n = 0; n < NL; n++) m_en[n] = 0;
            end
      'h2E0: m_ectl = d & 32'h0000_C000;
      default: ;
    endcase
  endtask

  task automatic rd(int unsigned a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = AW'(a);
    @(posedge clk); #0.5;
    bus_sel = 0;
    v = bus_rdata;
  endtask

  task automatic probe(int unsigned a);
    @(negedge clk);
    up_valid = 1; up_addr = AW'(a);
    @(posedge clk); #0.5;
    if (a >= 32'h80000) begin
      int unsigned l;
      l = (a - 32'h80000) / 32'h80000;
      if (!(l < NL && m_en[l])) m_bad = a;
    end
    @(negedge clk);
    up_valid = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int n = 0; n < NL; n++) m_en[n] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    live = 1;
    // R1 reset values
    rd('h0, v);  check("R1 mode reset", v, 0);
    rd('h10, v); check("R1 enable reset", v, 0);
    rd('h70, v); check("R1 bad addr reset", v, 0);
    check("R1 pulses reset", {26'h0, rst_masters, rst_links, rst_regs, clr_parity, brg_gen_rst, brg_err_rst}, 0);
    // R6 version
    rd('h74, v); check("R6 version", v, 32'h0000_0621);
    check("R1 rdata held", bus_rdata, 32'h0000_0621);
    wr('h74, 32'hFFFF_FFFF);
    rd('h74, v); check("R6 version ignores write", v, 32'h0000_0621);
    // R4 plug read
    rd('h18, v); check("R4 plug levels", v, 32'h9400_0000);
    // R2 mode/delay/rate
    wr('h0, 32'hFFFF_FFFF);
    rd('h0, v); check("R2 mode all ones", v, 32'hDFFF_FF10);
    wr('h0, 32'h8004_0110);
    rd('h0, v); check("R2 mode pattern", v, 32'h8004_0110);
    check("R2 clk_sel_a", 32'(clk_sel_a), 1);
    check("R2 clk_sel_b", 32'(clk_sel_b), 1);
    wr('h4, 32'hFFFF_0000);
    rd('h4, v); check("R2 delay", v, 32'hFFFF_0000);
    wr('h8, 32'h1234_5678);
    rd('h8, v); check("R2 rate", v, 32'h1234_5678);
    check("R2 rate out", rate_word, 32'h1234_5678);
    // R3 direct enable
    wr('h10, 32'hFFFF_FFFF);
    rd('h10, v); check("R3 unimplemented bits zero", v, 32'hFC00_0000);
    wr('h10, 32'h8000_0000);
    check("R3 link0 is msb", 32'(link_en), 32'h01);
    // R5 clear, R4 set
    wr('h10, 32'hFC00_0000);
    wr('h20, 32'h5000_0000);
    rd('h10, v); check("R5 clear selected", v, 32'hAC00_0000);
    wr('h20, 32'h0);
    rd('h10, v); check("R5 zero clear no effect", v, 32'hAC00_0000);
    wr('h18, 32'h4000_0000);
    rd('h10, v); check("R4 set ORs", v, 32'hEC00_0000);
    wr('h18, 32'h0);
    rd('h10, v); check("R4 zero set no effect", v, en_word());
    // R10 error control
    wr('h2E0, 32'hFFFF_FFFF);
    rd('h2E0, v); check("R10 ectl readback", v, 32'h0000_C000);
    // R7 pulses
    wr('hD0, 32'h3000_0000);
    check("R7 pulses set", {28'h0, rst_masters, rst_links, rst_regs, clr_parity}, 4'b1100);
    @(posedge clk); #0.5;
    check("R7 pulses one cycle", {28'h0, rst_masters, rst_links, rst_regs, clr_parity}, 0);
    rd('h10, v); check("R7 no regs wipe without bit27", v, 32'hEC00_0000);
    // R8 register wipe
    wr('hD0, 32'h0C00_0000);
    check("R8 regs/parity pulses", {28'h0, rst_masters, rst_links, rst_regs, clr_parity}, 4'b0011);
    rd('h0, v);  check("R8 mode wiped", v, 0);
    rd('h4, v);  check("R8 delay wiped", v, 0);
    rd('h2E0, v); check("R8 ectl wiped", v, 0);
    rd('h10, v); check("R8 enable wiped", v, 0);
    rd('h8, v);  check("R8 rate kept", v, 32'h1234_5678);
    // R9 bridge
    wr('h1D0, 32'hC000_0000);
    check("R9 bridge pulses", {30'h0, brg_gen_rst, brg_err_rst}, 2'b11);
    @(posedge clk); #0.5;
    check("R9 bridge pulses one cycle", {30'h0, brg_gen_rst, brg_err_rst}, 0);
    wr('h1D0, 32'h4000_0000);
    check("R9 error reset only", {30'h0, brg_gen_rst, brg_err_rst}, 2'b01);
    rd('h1D0, v); check("R9 error status", v, 32'hDEAD_0001);
    // R11/R12 windows
    wr('h10, 32'h8400_0000);
    probe('h80010);
    probe('h37FFFC);
    rd('h70, v); check("R11 no refusal latched", v, 0);
    probe('h180000);
    rd('h70, v); check("R12 disabled link refused", v, m_bad);
    probe('h400004);
    rd('h70, v); check("R12 unimplemented link refused", v, 32'h400004);
    probe('h001000);
    rd('h70, v); check("R12 register space not refused", v, 32'h400004);
    wr('h18, 32'h2000_0000);
    probe('h180040);
    rd('h70, v); check("R12 enabled link forwarded", v, 32'h400004);
    live = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule